// File: doc/BRIEF.md
# I2C Register Access Target

This block is a target-only I2C port that lets an external controller reach a bank of 256 eight-bit control registers. SCL and SDA are sampled by the system clock through short synchronizer chains. Start, repeated-start and stop conditions are recognised from edges on the sampled lines. A seven-bit device address is matched, and then bytes move between the bus and the registers. The block drives the bus only by pulling SDA low: `sda_oe` high means "pull the line low". It never drives SCL and never begins a transfer of its own.

The top six address bits are fixed as `101110`. The least significant address bit comes from a strap input. That input is followed while reset is held and frozen when reset is released. With the strap latched low, the write and read address bytes are 0xB8 and 0xB9. With it latched high, they are 0xBA and 0xBB. The first byte after a write address loads an eight-bit register pointer. Each data byte moved in either direction then advances the pointer by one. A read either follows a repeated start after the pointer byte, or starts directly from the pointer left by an earlier transfer.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges an address byte only if bits 7..1 equal `101110` followed by the latched strap bit. On any other address it leaves SDA released for the rest of that transfer, including its data, and no register changes.
- R2: The strap input is captured while `rst_n` is low, and the value present at reset release is kept. Later changes of the strap have no effect until the next reset. A latched 1 selects address bytes 0xBA/0xBB, and a latched 0 selects 0xB8/0xB9.
- R3: In a write, the target acknowledges the address byte (bit 0 = 0), the pointer byte and every data byte. Data bytes are stored, most significant bit first, into consecutive registers that start at the pointer value.
- R4: A combined read (write address, pointer byte, repeated start, read address with bit 0 = 1) returns the registers from the pointer value upward, one per byte, most significant bit first.
- R5: When the controller answers a read byte with NAK (SDA high during the ninth clock), the target releases SDA and keeps it released until the next start or stop.
- R6: The pointer wraps from 0xFF to 0x00, so a multi-byte transfer that starts at 0xFF continues at register 0x00.
- R7: A stop returns the target to idle and keeps the pointer value. A later read with no pointer byte continues at the register that follows the last one transferred.
- R8: After reset every register reads 0x00 and SDA is released.
- R9: The target changes its SDA drive only while SCL is low. Its acknowledge and data bits stay constant through each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_a0 | input | 1 | Level that sets address bit 0, frozen at reset release |
| scl_in | input | 1 | Sampled SCL bus line |
| sda_in | input | 1 | Sampled SDA bus line |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
At the end of a data byte, the register write and the pointer step happen on the same clock edge. The write must therefore use the pointer value from before the step, including when that step wraps from 0xFF to 0x00. The bench provokes this with a two-byte write that starts at 0xFF. It then reads back 0xFF and 0x00 in one combined read and compares the bytes against a scoreboard queue. The bench also judges the pointer carried across a stop by a bare read that must return the register after the last one written.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared state encoding for the I2C register target.
// Assumes: one byte-phase state machine in i2c_reg_target uses it.
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings one asynchronous bus line into the clock domain.
// It reports the synchronized level and one-cycle rise and fall pulses.
// Assumes: STAGES >= 2, and the line is idle high, so the chain resets to ones.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    // Shift chain: STAGES flops to synchronize, plus one for the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], line_in};
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];
    assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2c_reg_bank.sv
// Module: flat bank of control registers with one write port and a
// combinational read port.
// Assumes: at most one write per cycle, and every register clears on reset.
module i2c_reg_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage: clear every entry on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R3: a write is visible at its address on the following cycle.
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/i2c_reg_target.sv
// Module: target-only I2C port onto a bank of 8-bit registers.
// It detects start and stop, matches the address (bit 0 taken from a strap
// latched at reset release), loads a pointer, and writes or reads bytes
// while stepping the pointer.
// Assumes: clk is well over 8x the SCL rate, there is one controller, and no
// clock stretching.
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] ADDR_HI     = 6'b101110,
    parameter int         SYNC_STAGES = 2,
    parameter int         PTR_W       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_a0,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W);

    logic scl_s, scl_r, scl_f;
    logic sda_s, sda_r, sda_f;
    logic start_c, stop_c;
    logic a0_q;
    tgt_state_e state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic [PTR_W-1:0]  ptr;
    logic rw_q;
    logic m_ack;
    logic wr_en;
    logic [BYTE_W-1:0] rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in),
        .level(scl_s), .rise(scl_r), .fall(scl_f));

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in),
        .level(sda_s), .rise(sda_r), .fall(sda_f));

    i2c_reg_bank #(.ADDR_W(PTR_W), .DATA_W(BYTE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
        .wr_data(shreg), .rd_addr(ptr), .rd_data(rd_data));

    assign start_c = sda_f & scl_s;
    assign stop_c  = sda_r & scl_s;
    assign wr_en   = (state == ST_WR) && scl_f && (cnt == LAST_CNT);

    // Strap capture: follow the pin during reset, hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) a0_q <= strap_a0;
    end

    // Byte-phase state machine: shift on SCL rise, act on SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            tx     <= '0;
            ptr    <= '0;
            rw_q   <= 1'b0;
            m_ack  <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_c) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_c) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_SUB, ST_WR: begin
                    if (scl_r) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_f && cnt == LAST_CNT) begin
                        cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (shreg[BYTE_W-1:1] == {ADDR_HI, a0_q}) begin
                                rw_q   <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else if (state == ST_SUB) begin
                            ptr    <= shreg[PTR_W-1:0];
                            sda_oe <= 1'b1;
                            state  <= ST_SUB_ACK;
                        end else begin
                            ptr    <= ptr + 1'b1;
                            sda_oe <= 1'b1;
                            state  <= ST_WR_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_f) begin
                        if (rw_q) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            state  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_SUB;
                        end
                    end
                end
                ST_SUB_ACK, ST_WR_ACK: begin
                    if (scl_f) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_r) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_f) begin
                        if (cnt == LAST_CNT) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            state  <= ST_RD_ACK;
                        end else begin
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_r) begin
                        m_ack <= ~sda_s;
                    end else if (scl_f) begin
                        if (m_ack) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            state  <= ST_RD;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: the drive changes only while the sampled SCL is low.
    p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R2: the strap latch holds while out of reset.
    p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(a0_q));

    // R1: a target that has skipped the transfer never pulls SDA.
    p_skip_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);

    // R5: a NAK at the end of a read byte leaves SDA released.
    p_nak_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_f && !m_ack && !start_c && !stop_c) |=> !sda_oe);

    // R6: each stored byte moves the pointer one step, with wrap.
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(ptr) + 1'b1));

    // R8: SDA is released out of reset.
    p_reset_release_r8: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);
endmodule

// File: tb/i2c_reg_target_bench.sv
// Bench: drives the bus as a controller. A scoreboard queue holds the
// expected read bytes, and a monitor process compares each received byte.
module i2c_reg_target_bench;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b0;
    logic m_sda = 1'b1;
    logic m_scl = 1'b1;
    logic sda_oe;
    wire  sda_line = m_sda & ~sda_oe;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    always #10 clk = ~clk;

    i2c_reg_target u_i2c_reg_target (
        .clk(clk), .rst_n(rst_n), .strap_a0(strap),
        .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe));

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
        acked = !sda_line;
        wq(); m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit last);
        logic [7:0] b;
        logic mid;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1'b1; wq();
            b[i] = sda_line;
            mid = sda_line;
            repeat (Q - 1) @(negedge clk);
            check("R9 data bit held while SCL high", sda_line, mid);
            @(negedge clk);
            m_scl = 1'b0;
        end
        wq();
        m_sda = last; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0;
        obs_q.push_back(b);
        wq();
        if (last) check("R5 SDA released after NAK", sda_oe, 0);
        m_sda = 1'b1;
    endtask

    task automatic wr_regs(input string req, input logic [7:0] wa, input logic [7:0] sub,
                           input logic [7:0] d [4], input int n, input bit exp_ack);
        bit a;
        bus_start();
        send_byte(wa, a);  check({req, " address ack"}, a, exp_ack);
        send_byte(sub, a); check({req, " pointer ack"}, a, exp_ack);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a); check({req, " data ack"}, a, exp_ack);
        end
        bus_stop();
    endtask

    task automatic rd_regs(input string req, input logic [7:0] wa, input logic [7:0] sub,
                           input logic [7:0] e [4], input int n);
        bit a;
        bus_start();
        send_byte(wa, a);  check({req, " write address ack"}, a, 1);
        send_byte(sub, a); check({req, " pointer ack"}, a, 1);
        bus_rstart();
        send_byte(wa | 8'h01, a); check({req, " read address ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(e[i]); tag_q.push_back(req);
            recv_byte(i == n - 1);
        end
        bus_stop();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare each byte from the bus with the scoreboard head.
    initial begin
        forever begin
            wait (obs_q.size() > 0);
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
                void'(obs_q.pop_front());
            end else begin
                string t;
                logic [7:0] g, x;
                g = obs_q.pop_front(); x = exp_q.pop_front(); t = tag_q.pop_front();
                check(t, g, x);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [4];
        bit a;
        do_reset();
        check("R8 SDA released after reset", sda_oe, 0);
        d = '{8'h00, 8'h00, 8'h00, 8'h00};
        rd_regs("R8 registers clear", 8'hB8, 8'h40, d, 2);

        d = '{8'h11, 8'h22, 8'h33, 8'h00};
        wr_regs("R3 write burst", 8'hB8, 8'h10, d, 3, 1);
        rd_regs("R4 combined read", 8'hB8, 8'h10, d, 3);

        d = '{8'h99, 8'h00, 8'h00, 8'h00};
        wr_regs("R1 foreign address", 8'hBA, 8'h10, d, 1, 0);
        d = '{8'h11, 8'h00, 8'h00, 8'h00};
        rd_regs("R1 register untouched", 8'hB8, 8'h10, d, 1);

        d = '{8'hAA, 8'hBB, 8'h00, 8'h00};
        wr_regs("R6 write across wrap", 8'hB8, 8'hFF, d, 2, 1);
        rd_regs("R6 read across wrap", 8'hB8, 8'hFF, d, 2);

        d = '{8'h5A, 8'h6B, 8'h7C, 8'h00};
        wr_regs("R7 fill", 8'hB8, 8'h20, d, 3, 1);
        wr_regs("R7 set pointer", 8'hB8, 8'h20, d, 1, 1);
        bus_start();
        send_byte(8'hB9, a); check("R7 bare read address ack", a, 1);
        exp_q.push_back(8'h6B); tag_q.push_back("R7 pointer kept across stop");
        recv_byte(1);
        bus_stop();

        strap = 1'b1;
        repeat (4) @(negedge clk);
        d = '{8'h42, 8'h00, 8'h00, 8'h00};
        wr_regs("R2 strap change ignored", 8'hB8, 8'h30, d, 1, 1);
        wr_regs("R2 other address still foreign", 8'hBA, 8'h30, d, 1, 0);

        do_reset();
        strap = 1'b0;
        repeat (4) @(negedge clk);
        d = '{8'h00, 8'h00, 8'h00, 8'h00};
        rd_regs("R2 strap high selects BA and R8 clear", 8'hBA, 8'h30, d, 1);
        wr_regs("R2 B8 foreign after strap high", 8'hB8, 8'h30, d, 1, 0);

        wait (obs_q.size() == 0);
        check("scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule